// File: doc/BRIEF.md
# Microcontroller Execute and Write-Back Stage

This block is the last stage of a three-stage pipelined teaching microcontroller. Each cycle it accepts one decoded instruction: a 3-bit command, two source register indices, a destination index, a 32-bit immediate and a branch code. It reads the operands from its own 16 x 32-bit register file and performs one of eight operations. It writes the result back on the next rising edge, or latches a register onto the data output port. A taken compare-equal raises jump and flush.

A small two-state controller handles the branch. In state `ST_RUN`, instructions execute normally. The transition `RUN->SQUASH` fires on the edge that ends a taken compare-equal. In state `ST_SQUASH`, the stage drives flush, treats the incoming instructions as NOP and withdraws its operand read request. The transition `SQUASH->RUN` fires after `SQUASH_CYCLES` squashed cycles, which by default covers the two younger instructions still in the pipeline. Jump pulses during the first squashed cycle. The branch code that was captured stays on its output until the next taken branch.

A separate external store port can write any register in any cycle, including squashed cycles. A value written through that port is forwarded to operand reads in the same cycle.

Top module: `mcu_exec_stage`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears all 16 registers, `jump_o`, `flush_o`, `code_o` and `out_data_o` to zero.
- R2: LOAD (command 3'b101) writes `imm_i` into register `dst_i` at the edge that ends its cycle.
- R3: MOVE (3'b000) copies register `src_a_i` into register `dst_i`.
- R4: ADD (3'b001) writes `src_a + src_b` into `dst_i`. SUB (3'b010) writes `src_b - src_a`. Both wrap modulo 2^32.
- R5: MUL (3'b011) writes the low 32 bits of `src_a * src_b` into `dst_i`.
- R6: READ (3'b110) loads register `src_a_i` into `out_data_o` at the edge ending its cycle. `out_data_o` holds in every other cycle. READ and NOP (3'b111) write no register.
- R7: A CJE (3'b100) with equal source registers sets `flush_o` for exactly `SQUASH_CYCLES` cycles (2 by default), starting the cycle after. It pulses `jump_o` high for the first of those cycles only, and loads `code_i` into `code_o`. An unequal CJE changes none of these and writes no register.
- R8: While `flush_o` is high, the incoming command is executed as NOP: no register is written, `out_data_o` holds, and no further branch is taken.
- R9: `rd_req_o` is high in a cycle exactly when the command is MOVE, ADD, SUB, MUL, CJE or READ and `flush_o` is low.
- R10: When `ext_we_i` is high, `ext_data_i` is written into register `ext_dst_i`, even during flush. In that same cycle, any operand read of `ext_dst_i` sees `ext_data_i`.
- R11: When the external store and an execute write target the same register at the same edge, the external value is stored.
- R12: `imm_i` has no effect on any command other than LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Decoded command code |
| src_a_i | input | 4 | First source register index |
| src_b_i | input | 4 | Second source register index |
| dst_i | input | 4 | Destination register index |
| imm_i | input | 32 | Immediate for LOAD |
| code_i | input | 8 | Branch code passed out on a taken CJE |
| ext_we_i | input | 1 | External store strobe |
| ext_dst_i | input | 4 | External store register index |
| ext_data_i | input | 32 | External store data |
| out_data_o | output | 32 | Data output port loaded by READ |
| rd_req_o | output | 1 | Operand read request of the current command |
| jump_o | output | 1 | One-cycle pulse after a taken CJE |
| flush_o | output | 1 | High while younger instructions are squashed |
| code_o | output | 8 | Branch code of the last taken CJE |

## Verification
The assertions check the branch-controller behaviour on every cycle:
- jump is only seen together with flush, lasts one cycle, marks every rising edge of flush and comes with the captured code;
- a squashed or non-reading command never raises the read request;
- the output port never moves except after an unsquashed READ;
- reset leaves jump, flush and the output port at zero.

The arithmetic results, the forwarding of external stores, the write-collision priority, and the fact that squashed or non-LOAD immediates leave registers alone can only be shown by the bench's scenarios. The bench runs exhaustive sweeps over all register pairs and reads every result back through READ.

// File: rtl/mcu_exec_pkg.sv
package mcu_exec_pkg;

    typedef enum logic [2:0] {
        CMD_MOVE = 3'b000,
        CMD_ADD  = 3'b001,
        CMD_SUB  = 3'b010,
        CMD_MUL  = 3'b011,
        CMD_CJE  = 3'b100,
        CMD_LOAD = 3'b101,
        CMD_READ = 3'b110,
        CMD_NOP  = 3'b111
    } cmd_e;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_SQUASH = 1'b1
    } squash_st_e;

    // Commands that need the register file read ports.
    function automatic logic cmd_reads(cmd_e c);
        return !(c == CMD_LOAD || c == CMD_NOP);
    endfunction

endpackage

// File: rtl/exec_regfile.sv
module exec_regfile #(
    parameter int REGS   = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_addr,
    input  logic [IDX_W-1:0]  rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              ext_en,
    input  logic [IDX_W-1:0]  ext_addr,
    input  logic [DATA_W-1:0] ext_data
);

    logic [DATA_W-1:0] mem [REGS];

    // One storage word per register; the external store has priority.
    for (genvar g = 0; g < REGS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (ext_en && ext_addr == IDX_W'(g)) begin
                mem[g] <= ext_data;
            end else if (wb_en && wb_addr == IDX_W'(g)) begin
                mem[g] <= wb_data;
            end
        end
    end

    // Read ports with forwarding of a same-cycle external store.
    always_comb begin
        if (ext_en && ext_addr == rd_a_addr) begin
            rd_a_data = ext_data;
        end else begin
            rd_a_data = mem[rd_a_addr];
        end
        if (ext_en && ext_addr == rd_b_addr) begin
            rd_b_data = ext_data;
        end else begin
            rd_b_data = mem[rd_b_addr];
        end
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import mcu_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] imm,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              branch_eq
);

    always_comb begin
        wr_en     = 1'b0;
        result    = '0;
        branch_eq = 1'b0;
        unique case (cmd)
            CMD_MOVE: begin
                wr_en  = 1'b1;
                result = opa;
            end
            CMD_ADD: begin
                wr_en  = 1'b1;
                result = opa + opb;
            end
            CMD_SUB: begin
                wr_en  = 1'b1;
                result = opb - opa;
            end
            CMD_MUL: begin
                wr_en  = 1'b1;
                result = opa * opb;
            end
            CMD_CJE: begin
                branch_eq = (opa == opb);
            end
            CMD_LOAD: begin
                wr_en  = 1'b1;
                result = imm;
            end
            CMD_READ: begin
                wr_en = 1'b0;
            end
            CMD_NOP: begin
                wr_en = 1'b0;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/exec_squash_fsm.sv
module exec_squash_fsm
    import mcu_exec_pkg::*;
#(
    parameter int SQUASH_CYCLES = 2,
    parameter int CODE_W        = 8,
    localparam int CNT_W        = $clog2(SQUASH_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              squash_o,
    output logic              jump_o,
    output logic [CODE_W-1:0] code_o
);

    squash_st_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (take_i) begin
                    state_d = ST_SQUASH;
                    cnt_d   = CNT_W'(SQUASH_CYCLES - 1);
                end
            end
            ST_SQUASH: begin
                if (cnt_q == '0) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: jump pulse and captured branch code.
    always_ff @(posedge clk) begin
        if (rst) begin
            jump_o <= 1'b0;
            code_o <= '0;
        end else begin
            jump_o <= (state_q == ST_RUN) && take_i;
            if ((state_q == ST_RUN) && take_i) begin
                code_o <= code_i;
            end
        end
    end

    assign squash_o = (state_q == ST_SQUASH);

endmodule

// File: rtl/mcu_exec_stage.sv
module mcu_exec_stage
    import mcu_exec_pkg::*;
#(
    parameter int REGS          = 16,
    parameter int DATA_W        = 32,
    parameter int CODE_W        = 8,
    parameter int SQUASH_CYCLES = 2,
    localparam int IDX_W        = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic [IDX_W-1:0]  src_a_i,
    input  logic [IDX_W-1:0]  src_b_i,
    input  logic [IDX_W-1:0]  dst_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ext_we_i,
    input  logic [IDX_W-1:0]  ext_dst_i,
    input  logic [DATA_W-1:0] ext_data_i,
    output logic [DATA_W-1:0] out_data_o,
    output logic              rd_req_o,
    output logic              jump_o,
    output logic              flush_o,
    output logic [CODE_W-1:0] code_o
);

    cmd_e              eff_cmd;
    logic [DATA_W-1:0] opa, opb, alu_res;
    logic              alu_we, alu_eq;

    // A squashed instruction behaves as NOP.
    assign eff_cmd  = flush_o ? CMD_NOP : cmd_e'(cmd_i);
    assign rd_req_o = cmd_reads(eff_cmd);

    exec_regfile #(
        .REGS   (REGS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) rf_i (
        .clk       (clk),
        .rst       (rst),
        .rd_a_addr (src_a_i),
        .rd_b_addr (src_b_i),
        .rd_a_data (opa),
        .rd_b_data (opb),
        .wb_en     (alu_we),
        .wb_addr   (dst_i),
        .wb_data   (alu_res),
        .ext_en    (ext_we_i),
        .ext_addr  (ext_dst_i),
        .ext_data  (ext_data_i)
    );

    exec_alu #(
        .DATA_W (DATA_W)
    ) alu_i (
        .cmd       (eff_cmd),
        .opa       (opa),
        .opb       (opb),
        .imm       (imm_i),
        .wr_en     (alu_we),
        .result    (alu_res),
        .branch_eq (alu_eq)
    );

    exec_squash_fsm #(
        .SQUASH_CYCLES (SQUASH_CYCLES),
        .CODE_W        (CODE_W)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .take_i   (alu_eq),
        .code_i   (code_i),
        .squash_o (flush_o),
        .jump_o   (jump_o),
        .code_o   (code_o)
    );

    // Data output port, loaded only by an executed READ.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data_o <= '0;
        end else if (eff_cmd == CMD_READ) begin
            out_data_o <= opa;
        end
    end

endmodule

// File: rtl/mcu_exec_stage_chk.sv
module mcu_exec_stage_chk #(
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd_i,
    input logic [CODE_W-1:0] code_i,
    input logic [DATA_W-1:0] out_data_o,
    input logic              rd_req_o,
    input logic              jump_o,
    input logic              flush_o,
    input logic [CODE_W-1:0] code_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!jump_o && !flush_o && out_data_o == '0 && code_o == '0));

    // R7
    jump_in_flush_chk: assert property (@(posedge clk) disable iff (rst)
        jump_o |-> flush_o);

    // R7
    jump_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        jump_o |=> !jump_o);

    // R7
    flush_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && flush_o && !$past(flush_o)) |-> jump_o);

    // R7
    code_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && jump_o) |-> (code_o == $past(code_i)));

    // R8
    squash_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> !rd_req_o);

    // R9
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'b101 || cmd_i == 3'b111) |-> !rd_req_o);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(cmd_i) == 3'b110 && !$past(flush_o)))
            |-> $stable(out_data_o));

endmodule

bind mcu_exec_stage mcu_exec_stage_chk #(
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd_i),
    .code_i     (code_i),
    .out_data_o (out_data_o),
    .rd_req_o   (rd_req_o),
    .jump_o     (jump_o),
    .flush_o    (flush_o),
    .code_o     (code_o)
);

// File: tb/mcu_exec_stage_tb_top.sv
`timescale 1ns/1ps
module mcu_exec_stage_tb_top;
    import mcu_exec_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_i = 3'b111;
    logic [3:0]  src_a_i = '0, src_b_i = '0, dst_i = '0, ext_dst_i = '0;
    logic [31:0] imm_i = '0, ext_data_i = '0;
    logic [7:0]  code_i = '0;
    logic        ext_we_i = 1'b0;
    logic [31:0] out_data_o;
    logic        rd_req_o, jump_o, flush_o;
    logic [7:0]  code_o;

    always #4 clk = ~clk;

    mcu_exec_stage dut_i (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .dst_i(dst_i), .imm_i(imm_i), .code_i(code_i), .ext_we_i(ext_we_i),
        .ext_dst_i(ext_dst_i), .ext_data_i(ext_data_i), .out_data_o(out_data_o),
        .rd_req_o(rd_req_o), .jump_o(jump_o), .flush_o(flush_o), .code_o(code_o)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m [16];
    logic [31:0] exp_out = '0;
    logic [7:0]  exp_code = '0;
    logic        exp_jump = 1'b0;
    int          sq_left = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge, apply it at the next rising
    // edge and update the bench model, then check the branch outputs.
    task automatic step(input logic [2:0] c, input int a, input int b, input int d,
                        input logic [31:0] imm, input logic [7:0] code,
                        input bit xe = 1'b0, input int xd = 0,
                        input logic [31:0] xv = '0);
        logic [31:0] av, bv, res;
        bit          we, taken, exp_req;
        cmd_i = c; src_a_i = 4'(a); src_b_i = 4'(b); dst_i = 4'(d);
        imm_i = imm; code_i = code; ext_we_i = xe; ext_dst_i = 4'(xd); ext_data_i = xv;
        #1;
        exp_req = (sq_left == 0) && (c != 3'b101) && (c != 3'b111);
        chk(rd_req_o == exp_req, (sq_left > 0) ? "R8 rd_req" : "R9 rd_req",
            32'(rd_req_o), 32'(exp_req));
        av = (xe && xd == a) ? xv : m[a];
        bv = (xe && xd == b) ? xv : m[b];
        we = 1'b0; taken = 1'b0; res = '0;
        if (sq_left == 0) begin
            case (c)
                3'b000: begin we = 1'b1; res = av; end
                3'b001: begin we = 1'b1; res = av + bv; end
                3'b010: begin we = 1'b1; res = bv - av; end
                3'b011: begin we = 1'b1; res = av * bv; end
                3'b100: taken = (av == bv);
                3'b101: begin we = 1'b1; res = imm; end
                3'b110: exp_out = av;
                default: ;
            endcase
        end
        if (sq_left > 0) begin
            sq_left--;
            exp_jump = 1'b0;
        end else if (taken) begin
            sq_left  = 2;
            exp_jump = 1'b1;
            exp_code = code;
        end else begin
            exp_jump = 1'b0;
        end
        if (we) m[d] = res;
        if (xe) m[xd] = xv;
        @(negedge clk);
        ext_we_i = 1'b0;
        chk(flush_o == (sq_left > 0), "R7 flush", 32'(flush_o), 32'(sq_left > 0));
        chk(jump_o == exp_jump, "R7 jump", 32'(jump_o), 32'(exp_jump));
        chk(code_o == exp_code, "R7 code", 32'(code_o), 32'(exp_code));
        chk(out_data_o == exp_out, "R6 out hold/load", out_data_o, exp_out);
    endtask

    task automatic nop();
        step(3'b111, 0, 0, 0, '0, '0);
    endtask

    // READ register idx and compare against the model.
    task automatic rd_chk(input int idx, input string req);
        step(3'b110, idx, 0, 0, '0, '0);
        chk(out_data_o == m[idx], req, out_data_o, m[idx]);
    endtask

    function automatic logic [31:0] pat(input int i, input int salt);
        return (32'h9E37_79B9 * 32'(i + 1 + salt)) ^ 32'(i << 3);
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(jump_o == 1'b0 && flush_o == 1'b0, "R1 jump/flush", {jump_o, flush_o}, 0);
        chk(out_data_o == 0, "R1 out", out_data_o, 0);
        chk(code_o == 0, "R1 code", 32'(code_o), 0);
        for (int i = 0; i < 16; i++) rd_chk(i, "R1 reg cleared");

        // R2 LOAD sweep
        for (int i = 0; i < 16; i++) step(3'b101, 0, 0, i, pat(i, 0), '0);
        for (int i = 0; i < 16; i++) rd_chk(i, "R2 load");

        // R3 MOVE sweep
        for (int i = 0; i < 16; i++) begin
            step(3'b000, i, 0, (i + 5) % 16, 32'h5555_0000, '0);
            rd_chk((i + 5) % 16, "R3 move");
        end

        // R4 / R5 exhaustive register pairs
        for (int op = 1; op <= 3; op++) begin
            for (int i = 0; i < 16; i++) step(3'b101, 0, 0, i, pat(i, op * 7), '0);
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    step(3'(op), i, j, (i * 3 + j) % 16, '0, '0);
                    rd_chk((i * 3 + j) % 16, (op == 3) ? "R5 mul" : "R4 add/sub");
                end
            end
        end
        // R4 wrap corners
        step(3'b101, 0, 0, 1, 32'hFFFF_FFFF, '0);
        step(3'b101, 0, 0, 2, 32'h0000_0002, '0);
        step(3'b001, 1, 2, 3, '0, '0);
        rd_chk(3, "R4 add wrap");
        chk(out_data_o == 32'h1, "R4 add wrap value", out_data_o, 32'h1);
        step(3'b010, 1, 2, 4, '0, '0);
        rd_chk(4, "R4 sub b-a");
        chk(out_data_o == 32'h3, "R4 sub value", out_data_o, 32'h3);
        step(3'b011, 1, 1, 5, '0, '0);
        chk(1'b1, "R5", 0, 0);
        rd_chk(5, "R5 mul low bits");

        // R12 immediate ignored by non-LOAD commands
        step(3'b001, 1, 2, 6, 32'hDEAD_BEEF, '0);
        rd_chk(6, "R12 add imm ignored");
        step(3'b000, 2, 0, 7, 32'hCAFE_F00D, '0);
        rd_chk(7, "R12 move imm ignored");

        // R6 READ/NOP write nothing
        step(3'b111, 0, 0, 3, 32'h1234_5678, '0);
        step(3'b110, 2, 0, 3, 32'h1234_5678, '0);
        rd_chk(3, "R6 no write");

        // R9 read request for every command, not taken CJE
        for (int c = 0; c < 8; c++) step(3'(c), 1, 2, 8, 32'h77, 8'h11);
        rd_chk(8, "R9 sweep state");

        // R7 / R8 taken branch
        step(3'b101, 0, 0, 9, 32'hABCD, '0);
        step(3'b101, 0, 0, 10, 32'hABCD, '0);
        step(3'b100, 9, 10, 0, '0, 8'h5A);
        chk(jump_o && flush_o && code_o == 8'h5A, "R7 taken", {jump_o, flush_o, code_o}, 32'h35A);
        step(3'b101, 0, 0, 11, 32'hFFFF_0000, '0);
        step(3'b110, 9, 0, 0, '0, '0);
        chk(flush_o == 1'b0, "R7 flush length", 32'(flush_o), 0);
        rd_chk(11, "R8 squashed load");
        // back-to-back CJE inside squash does not re-branch
        step(3'b100, 9, 10, 0, '0, 8'h21);
        step(3'b100, 9, 10, 0, '0, 8'h22);
        step(3'b100, 9, 10, 0, '0, 8'h23);
        chk(code_o == 8'h21, "R8 no branch in squash", 32'(code_o), 32'h21);
        nop(); nop();
        // unequal CJE
        step(3'b100, 9, 11, 0, '0, 8'h99);
        chk(!flush_o && !jump_o && code_o == 8'h21, "R7 not taken",
            {jump_o, flush_o, code_o}, 32'h21);

        // R10 external store sweep and forwarding
        for (int i = 0; i < 16; i++) begin
            step(3'b111, 0, 0, 0, '0, '0, 1'b1, i, pat(i, 99));
            rd_chk(i, "R10 ext store");
        end
        step(3'b000, 8, 0, 12, '0, '0, 1'b1, 8, 32'h0BAD_F00D);
        rd_chk(12, "R10 forward");
        chk(out_data_o == 32'h0BAD_F00D, "R10 forward value", out_data_o, 32'h0BAD_F00D);
        step(3'b100, 1, 1, 0, '0, 8'h44);
        step(3'b111, 0, 0, 0, '0, '0, 1'b1, 13, 32'h1357_9BDF);
        nop();
        rd_chk(13, "R10 store during flush");

        // R11 collision
        step(3'b101, 0, 0, 14, 32'hAAAA_AAAA, '0, 1'b1, 14, 32'h5555_5555);
        rd_chk(14, "R11 ext wins");
        chk(out_data_o == 32'h5555_5555, "R11 value", out_data_o, 32'h5555_5555);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule